// File: doc/BRIEF.md
# Chainable Serial Shift Slave

This block is a serial-bus slave with one fixed word length, built to be wired in series with copies of itself. All copies share a single active-low select line. Each copy's serial output drives the serial input of the next copy. While select is low, every rising serial clock takes in one bit at the bottom of a shift register. Every falling serial clock moves the register up by one place, and its top bit is always the serial output. As a result, the word a copy took in during one select window leaves it unchanged during the next window, and a chain of K copies acts as one K×WIDTH-bit shift register.

When select returns high, the register contents are copied to a parallel output bank, for example to drive a set of outputs. When select goes low and the load enable is high, a parallel input bank replaces the register contents. The bank is then sent up the chain in place of the forwarded word. The serial clock idles low: bits are sampled on the rising edge and the output moves on the falling edge. The serial pins are brought into the block's clock domain through synchronizer flops.

The controller has three states. IDLE means select is inactive. CAPTURE means the serial clock is low, and the block waits for a rising edge. SHIFT means the serial clock is high, and the block waits for a falling edge. The transitions are as follows. IDLE→CAPTURE on select low, loading the parallel bank if enabled. CAPTURE→SHIFT on serial clock high, sampling the input bit. SHIFT→CAPTURE on serial clock low, shifting the register. CAPTURE→IDLE and SHIFT→IDLE on select high, latching the parallel output.

Top module: `dchain_slave`

## Requirements
- R1: After reset, the serial output is 0, the parallel output is all zeros and the shift register is cleared.
- R2: While select is high, toggling the serial clock and serial input changes neither the serial output, the parallel output nor the stored word.
- R3: Words leave most significant bit first. The serial output always shows the top bit of the register, and each shift brings the next lower bit to it.
- R4: With load disabled, the bits received during one select window are sent out unchanged, in the same order, during the next window.
- R5: The parallel output takes the register contents only when select rises, and holds its value during a window.
- R6: If load enable is high when select falls, the parallel input bank replaces the register contents and is shifted out MSB first.
- R7: If load enable is low when select falls, the register keeps its previous contents.
- R8: The serial output changes only after a falling serial clock edge or a load, so it is stable while the serial clock is high.
- R9: Three chained copies clocked with 3×WIDTH bits under one select hold the last WIDTH bits in the first copy, the middle WIDTH bits in the second and the first WIDTH bits in the third.
- R10: A window with more or fewer than WIDTH clocks per copy keeps shifting bit by bit, and on select rise each parallel output holds that copy's current register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles low |
| sel_n | input | 1 | Shared select, active low |
| sdi | input | 1 | Serial data in (from the previous copy or the host) |
| sdo | output | 1 | Serial data out (to the next copy) |
| load_en | input | 1 | Load the parallel input bank at select fall |
| par_in | input | WIDTH | Parallel input bank |
| par_out | output | WIDTH | Parallel output latch, updated at select rise |

## Verification
The bench drives three chained copies and compares them with a 24-bit shift-register model. Full 3×WIDTH windows with distinct patterns separate the placement of each slice from the forwarding of the previous window's word. Serial clock and data activity with select high shows whether the idle state is truly ignored. A parallel load into the middle copy alone shows whether loading replaces only that slice. Windows that are too long and too short show whether shifting is bit-exact rather than word-framed.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_SHIFT   = 2'd2
    } dchain_state_e;
endpackage

// File: rtl/dchain_sync.sv
module dchain_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dchain_ctrl.sv
module dchain_ctrl
    import dchain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_s,
    input  logic sclk_s,
    input  logic load_en,
    output logic load_o,
    output logic sample_o,
    output logic shift_o,
    output logic latch_o
);
    dchain_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (!sel_s) state_d = ST_CAPTURE;
            ST_CAPTURE: if (sel_s) state_d = ST_IDLE;
                        else if (sclk_s) state_d = ST_SHIFT;
            ST_SHIFT:   if (sel_s) state_d = ST_IDLE;
                        else if (!sclk_s) state_d = ST_CAPTURE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o   = 1'b0;
        sample_o = 1'b0;
        shift_o  = 1'b0;
        latch_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:    load_o = !sel_s && load_en;
            ST_CAPTURE: begin
                latch_o  = sel_s;
                sample_o = !sel_s && sclk_s;
            end
            ST_SHIFT:   begin
                latch_o = sel_s;
                shift_o = !sel_s && !sclk_s;
            end
            default:    latch_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dchain_shreg.sv
module dchain_shreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             sample,
    input  logic             shift,
    input  logic             latch,
    input  logic             sdi_s,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] word_o,
    output logic [WIDTH-1:0] par_out
);
    logic [WIDTH-1:0] word_q;
    logic             bit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            bit_q   <= 1'b0;
            par_out <= '0;
        end else begin
            if (sample) bit_q <= sdi_s;
            if (load)
                word_q <= par_in;
            else if (shift)
                word_q <= {word_q[WIDTH-2:0], bit_q};
            if (latch) par_out <= word_q;
        end
    end

    assign word_o = word_q;
endmodule

// File: rtl/dchain_slave.sv
module dchain_slave #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             sel_n,
    input  logic             sdi,
    output logic             sdo,
    input  logic             load_en,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] par_out
);
    localparam int NPINS = 3;

    logic [NPINS-1:0] pins_s;
    logic             sclk_s, sel_s, sdi_s;
    logic             load_s, sample_s, shift_s, latch_s;
    logic [WIDTH-1:0] shreg_q;

    dchain_sync #(
        .WIDTH  (NPINS),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({sclk, sel_n, sdi}),
        .sync_o (pins_s)
    );

    assign {sclk_s, sel_s, sdi_s} = pins_s;

    dchain_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_s   (sel_s),
        .sclk_s  (sclk_s),
        .load_en (load_en),
        .load_o  (load_s),
        .sample_o(sample_s),
        .shift_o (shift_s),
        .latch_o (latch_s)
    );

    dchain_shreg #(.WIDTH(WIDTH)) u_shreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_s),
        .sample (sample_s),
        .shift  (shift_s),
        .latch  (latch_s),
        .sdi_s  (sdi_s),
        .par_in (par_in),
        .word_o (shreg_q),
        .par_out(par_out)
    );

    assign sdo = shreg_q[WIDTH-1];
endmodule

// File: rtl/dchain_slave_chk.sv
module dchain_slave_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] par_out,
    input logic             sdo,
    input logic [WIDTH-1:0] shreg,
    input logic             load_s,
    input logic             shift_s,
    input logic             latch_s
);
    // R5
    par_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(par_out) |-> $past(latch_s));

    // R5
    par_out_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_s |=> par_out == $past(shreg));

    // R8
    sdo_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(shift_s || load_s));

    // R3
    msb_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_s && !load_s) |=> sdo == $past(shreg[WIDTH-2]));

    // R6
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_s |=> shreg == $past(par_in));
endmodule

bind dchain_slave dchain_slave_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .par_in (par_in),
    .par_out(par_out),
    .sdo    (sdo),
    .shreg  (shreg_q),
    .load_s (load_s),
    .shift_s(shift_s),
    .latch_s(latch_s)
);

// File: tb/dchain_slave_test.sv
module dchain_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 8;
    localparam int NDEV = 3;
    localparam int CW   = W * NDEV;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sel_n = 1'b1;
    logic sdi = 1'b0;
    logic [NDEV-1:0] le = '0;
    logic [W-1:0] pin [NDEV];
    logic [W-1:0] pout [NDEV];
    logic [NDEV-1:0] so;

    int checks = 0;
    int errors = 0;

    logic [CW-1:0] chain_m = '0;
    logic [W-1:0]  pout_m [NDEV];

    always #(CLK_PERIOD/2) clk = ~clk;

    dchain_slave #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sel_n(sel_n), .sdi(sdi),
        .sdo(so[0]), .load_en(le[0]), .par_in(pin[0]), .par_out(pout[0]));
    dchain_slave #(.WIDTH(W)) u1 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sel_n(sel_n), .sdi(so[0]),
        .sdo(so[1]), .load_en(le[1]), .par_in(pin[1]), .par_out(pout[1]));
    dchain_slave #(.WIDTH(W)) u2 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sel_n(sel_n), .sdi(so[1]),
        .sdo(so[2]), .load_en(le[2]), .par_in(pin[2]), .par_out(pout[2]));

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic check_pouts(input string tag);
        for (int d = 0; d < NDEV; d++) check(tag, 32'(pout[d]), 32'(pout_m[d]));
    endtask

    // One select window of nbits bits, checked against the chain model.
    task automatic run_window(input logic [31:0] data, input int nbits, input string tag);
        logic [31:0] got_v, exp_v;
        logic        m_hi;
        logic [W-1:0] p0_before;
        got_v = '0;
        exp_v = '0;
        p0_before = pout[0];
        for (int d = 0; d < NDEV; d++)
            if (le[d]) chain_m[d*W +: W] = pin[d];
        @(negedge clk);
        sel_n = 1'b0;
        wait_clks(HALF);
        for (int i = 0; i < nbits; i++) begin
            sdi = data[nbits-1-i];
            wait_clks(HALF);
            got_v = {got_v[30:0], so[2]};
            exp_v = {exp_v[30:0], chain_m[CW-1]};
            chain_m = {chain_m[CW-2:0], data[nbits-1-i]};
            sclk = 1'b1;
            wait_clks(2);
            m_hi = so[0];
            wait_clks(HALF-2);
            // R8: output steady through the high phase
            check("R8 sdo stable while sclk high", 32'(so[0]), 32'(m_hi));
            if (i == nbits/2)
                check("R5 par_out held in window", 32'(pout[0]), 32'(p0_before));
            sclk = 1'b0;
        end
        wait_clks(HALF);
        sel_n = 1'b1;
        wait_clks(HALF);
        for (int d = 0; d < NDEV; d++) pout_m[d] = chain_m[d*W +: W];
        check({tag, " chain out"}, got_v, exp_v);
        check_pouts({tag, " par_out"});
    endtask

    task automatic test_reset();
        for (int d = 0; d < NDEV; d++) begin
            check("R1 reset sdo", 32'(so[d]), 32'h0);
            check("R1 reset par_out", 32'(pout[d]), 32'h0);
        end
    endtask

    task automatic test_chain_word();
        // R9: first-sent byte lands in the last copy
        run_window(32'h00A5_3C96, CW, "R9 place");
        check("R9 u2 slice", 32'(pout[2]), 32'hA5);
        check("R9 u1 slice", 32'(pout[1]), 32'h3C);
        check("R9 uut slice", 32'(pout[0]), 32'h96);
    endtask

    task automatic test_forward();
        logic first;
        // R4 / R3: next window carries the previous word, MSB first
        @(negedge clk);
        sel_n = 1'b0;
        wait_clks(HALF);
        first = so[2];
        check("R3 first bit is MSB", 32'(first), 32'h1);
        sel_n = 1'b1;
        wait_clks(HALF);
        run_window(32'h0012_E47B, CW, "R4 forward");
    endtask

    task automatic test_idle_ignored();
        logic [NDEV-1:0] so_before;
        so_before = so;
        // R2: activity with select high
        for (int i = 0; i < 10; i++) begin
            sdi = i[0];
            sclk = 1'b1;
            wait_clks(HALF);
            sclk = 1'b0;
            wait_clks(HALF);
        end
        check("R2 sdo unchanged", 32'(so), 32'(so_before));
        check_pouts("R2 par_out unchanged");
        run_window(32'h0055_AA0F, CW, "R2 word kept");
    endtask

    task automatic test_parallel_load();
        pin[0] = 8'h11; pin[1] = 8'hC7; pin[2] = 8'h22;
        le = 3'b010;
        // R6 for the middle copy, R7 for the others
        run_window(32'h0000_0000, CW, "R6 R7 load");
        le = '0;
        run_window(32'h0081_4242, CW, "R6 bank forwarded");
    endtask

    task automatic test_odd_windows();
        // R10: longer and shorter than a word per copy
        run_window(32'h0F1E_2D3C, CW + 4, "R10 long");
        run_window(32'h0000_000B, 4, "R10 short");
    endtask

    initial begin
        pin[0] = '0; pin[1] = '0; pin[2] = '0;
        for (int d = 0; d < NDEV; d++) pout_m[d] = '0;
        wait_clks(4);
        rst_n = 1'b1;
        wait_clks(4);
        test_reset();
        test_chain_word();
        test_forward();
        test_idle_ignored();
        test_parallel_load();
        test_odd_windows();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule